// File: doc/BRIEF.md
# Majority-Stepped Triple Shift-Register Keystream Generator

This block generates a keystream one bit per clock from three linear feedback shift registers of 19, 22 and 23 bits and combines it with a serial data bit by XOR. The same block serves as encryptor and decryptor: feeding plaintext yields ciphertext, and feeding ciphertext with the same key yields plaintext.

Operation has two phases. A load strobe fills all three registers from a 64-bit key and raises the ready flag. After that, every cycle with valid data applies an irregular step. Each register takes one clocking bit. A register advances only when its clocking bit matches the majority value of the three clocking bits, so at least two registers move on every step.

The keystream bit and the combined data bit are combinational functions of the current register contents and the data input. The registers then step at the clock edge that consumes the data bit. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `mc3_keystream`

## Requirements
- R1: During reset, and after reset until the first load, ready_o is 0, keystream_o is 0 and data_o equals data_i.
- R2: A load_i pulse copies the key into the registers. Key bits 0..18 go to register A (key bit i to A bit i), bits 19..40 go to register B (key bit 19+i to B bit i), and bits 41..63 go to register C (key bit 41+i to C bit i). ready_o reads 1 from the next cycle.
- R3: keystream_o is the XOR of the top bits of the three registers (A bit 18, B bit 21, C bit 22), taken from the current contents.
- R4: data_o equals data_i XOR keystream_o in the same cycle.
- R5: The clocking bits are A bit 8, B bit 10 and C bit 10. The majority value is 1 when two or more of them are 1. On a step, only the registers whose clocking bit equals the majority advance, so at least two advance.
- R6: An advancing register moves every bit up one place and takes into bit 0 the XOR of its taps. The taps are bits 18, 17, 16 and 13 for A, bits 21 and 20 for B, and bits 22, 21, 20 and 7 for C.
- R7: A step happens only in a cycle with ready_o high, data_valid_i high and load_i low. In any other cycle the registers hold and keystream_o does not change.
- R8: When load_i and data_valid_i are both high, the load wins. The next cycle shows the keystream of the fresh key, with no step applied.
- R9: data_valid_i before the first load is ignored. ready_o stays 0 and keystream_o stays 0.
- R10: Once high, ready_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 64 | Key loaded into the three registers |
| load_i | input | 1 | Load strobe |
| data_i | input | 1 | Serial data bit to combine |
| data_valid_i | input | 1 | data_i is valid; consume it and step |
| keystream_o | output | 1 | Current keystream bit |
| data_o | output | 1 | data_i XOR keystream bit |
| ready_o | output | 1 | Registers hold a loaded key |

## Verification
The bench builds the block with its default parameters: register lengths 19, 22 and 23, the stated tap sets, and clocking bits 8, 10 and 10. With these values, random keys and hundreds of steps per key reach all eight clocking-bit combinations, so every register is seen both stalling and advancing. Directed keys place single ones on the top bits to pin down which register feeds the keystream. Random gaps in data_valid_i, loads that collide with valid data, and a reset in mid-stream cover the hold, priority and restart rules.

// File: rtl/mc3_pkg.sv
package mc3_pkg;
  typedef enum logic {PH_EMPTY = 1'b0, PH_RUN = 1'b1} mc3_phase_e;

  localparam int A_LEN = 19;
  localparam int B_LEN = 22;
  localparam int C_LEN = 23;

  localparam logic [A_LEN-1:0] A_TAPS = A_LEN'((1 << 18) | (1 << 17) | (1 << 16) | (1 << 13));
  localparam logic [B_LEN-1:0] B_TAPS = B_LEN'((1 << 21) | (1 << 20));
  localparam logic [C_LEN-1:0] C_TAPS = C_LEN'((1 << 22) | (1 << 21) | (1 << 20) | (1 << 7));

  localparam int A_CLK = 8;
  localparam int B_CLK = 10;
  localparam int C_CLK = 10;
endpackage

// File: rtl/mc3_majority.sv
module mc3_majority #(
  parameter int N = 3
) (
  input  logic [N-1:0] vote_i,
  output logic         maj_o,
  output logic [N-1:0] move_o
);
  localparam int HALF = N / 2;

  always_comb begin
    maj_o = ($countones(vote_i) > HALF);
    for (int i = 0; i < N; i++) begin
      move_o[i] = (vote_i[i] == maj_o);
    end
  end

  // R5: a majority always agrees with more than half of the voters
  always_comb begin
    if (!$isunknown(vote_i)) begin
      p_two_move_r5: assert ($countones(move_o) > HALF)
        else $error("majority stepping moved too few registers");
    end
  end
endmodule

// File: rtl/mc3_lfsr.sv
module mc3_lfsr #(
  parameter int              LEN     = 19,
  parameter logic [LEN-1:0]  TAPS    = '0,
  parameter int              CLK_BIT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [LEN-1:0] load_val_i,
  input  logic           shift_i,
  output logic           msb_o,
  output logic           vote_o
);
  logic [LEN-1:0] state_q, state_d;
  logic           fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (load_i) begin
      state_d = load_val_i;
    end else if (shift_i) begin
      state_d = {state_q[LEN-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (load_i || shift_i) begin
      state_q <= state_d;
    end
  end

  assign msb_o  = state_q[LEN-1];
  assign vote_o = state_q[CLK_BIT];

  // R6: an advancing register moves its contents up by one place
  p_shift_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (state_q[LEN-1:1] == $past(state_q[LEN-2:0])));

  // R7: no load and no shift means the contents hold
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> $stable(state_q));

  // R2: a load places the key slice in the register
  p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (state_q == $past(load_val_i)));
endmodule

// File: rtl/mc3_keystream.sv
module mc3_keystream
  import mc3_pkg::*;
#(
  parameter int              LEN_A  = A_LEN,
  parameter int              LEN_B  = B_LEN,
  parameter int              LEN_C  = C_LEN,
  parameter logic [LEN_A-1:0] TAPS_A = A_TAPS,
  parameter logic [LEN_B-1:0] TAPS_B = B_TAPS,
  parameter logic [LEN_C-1:0] TAPS_C = C_TAPS,
  parameter int              CLK_A  = A_CLK,
  parameter int              CLK_B  = B_CLK,
  parameter int              CLK_C  = C_CLK,
  localparam int             KEY_W  = LEN_A + LEN_B + LEN_C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_i,
  input  logic             load_i,
  input  logic             data_i,
  input  logic             data_valid_i,
  output logic             keystream_o,
  output logic             data_o,
  output logic             ready_o
);
  localparam int B_LO = LEN_A;
  localparam int C_LO = LEN_A + LEN_B;

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  mc3_phase_e  phase_q, phase_d;
  logic        step;
  logic [2:0]  votes, moves, msbs;
  logic        maj;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    phase_d = phase_q;
    if (load_i) begin
      phase_d = PH_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      phase_q <= PH_EMPTY;
    end else if (load_i) begin
      phase_q <= phase_d;
    end
  end

  assign ready_o = (phase_q == PH_RUN);
  assign step    = ready_o && data_valid_i && !load_i;

  mc3_majority #(.N(3)) u_vote (
    .vote_i (votes),
    .maj_o  (maj),
    .move_o (moves)
  );

  mc3_lfsr #(.LEN(LEN_A), .TAPS(TAPS_A), .CLK_BIT(CLK_A)) u_reg_a (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load_i),
    .load_val_i (key_i[LEN_A-1:0]),
    .shift_i    (step && moves[0]),
    .msb_o      (msbs[0]),
    .vote_o     (votes[0])
  );

  mc3_lfsr #(.LEN(LEN_B), .TAPS(TAPS_B), .CLK_BIT(CLK_B)) u_reg_b (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load_i),
    .load_val_i (key_i[C_LO-1:B_LO]),
    .shift_i    (step && moves[1]),
    .msb_o      (msbs[1]),
    .vote_o     (votes[1])
  );

  mc3_lfsr #(.LEN(LEN_C), .TAPS(TAPS_C), .CLK_BIT(CLK_C)) u_reg_c (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (load_i),
    .load_val_i (key_i[KEY_W-1:C_LO]),
    .shift_i    (step && moves[2]),
    .msb_o      (msbs[2]),
    .vote_o     (votes[2])
  );

  assign keystream_o = ^msbs;
  assign data_o      = data_i ^ keystream_o;

  // R2: a load makes the block ready on the next cycle
  p_ready_after_load_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_i |=> ready_o);

  // R10: ready never drops without reset
  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ready_o |=> ready_o);

  // R7: without a step or load the keystream bit holds
  p_ks_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!step && !load_i) |=> $stable(keystream_o));

  // R9: before any load the keystream stays zero
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ready_o |-> !keystream_o);
endmodule

// File: tb/mc3_keystream_bench.sv
module mc3_keystream_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] key;
  logic        load, din, dvalid;
  logic        ks, dout, rdy;

  int checks = 0;
  int fails  = 0;

  logic [31:0] ma, mb, mc;
  logic        mready;

  localparam logic [31:0] TA = (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 16) | (32'd1 << 13);
  localparam logic [31:0] TB = (32'd1 << 21) | (32'd1 << 20);
  localparam logic [31:0] TC = (32'd1 << 22) | (32'd1 << 21) | (32'd1 << 20) | (32'd1 << 7);

  always #2 clk = ~clk;

  mc3_keystream u_mc3_keystream (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_i        (key),
    .load_i       (load),
    .data_i       (din),
    .data_valid_i (dvalid),
    .keystream_o  (ks),
    .data_o       (dout),
    .ready_o      (rdy)
  );

  function automatic logic [31:0] adv(logic [31:0] s, int len, logic [31:0] taps);
    logic        fb;
    logic [31:0] msk;
    fb  = ^(s & taps);
    msk = (32'd1 << len) - 32'd1;
    return ((s << 1) | {31'd0, fb}) & msk;
  endfunction

  function automatic logic model_ks();
    return ma[18] ^ mb[21] ^ mc[22];
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before posedge, update model after it
  task automatic cycle(input logic ld, input logic [63:0] k, input logic v, input logic d, input string tag);
    logic m, va, vb, vc;
    @(negedge clk);
    load = ld; key = k; dvalid = v; din = d;
    #1;
    check(rdy == mready, {tag, " ready"}, 64'(rdy), 64'(mready));
    check(ks == model_ks(), {tag, " keystream R3"}, 64'(ks), 64'(model_ks()));
    check(dout == (d ^ model_ks()), {tag, " data R4"}, 64'(dout), 64'(d ^ model_ks()));
    @(posedge clk);
    if (ld) begin
      ma = {13'd0, k[18:0]}; mb = {10'd0, k[40:19]}; mc = {9'd0, k[63:41]};
      mready = 1'b1;
    end else if (v && mready) begin
      va = ma[8]; vb = mb[10]; vc = mc[10];
      m  = (va & vb) | (va & vc) | (vb & vc);
      if (va == m) ma = adv(ma, 19, TA);
      if (vb == m) mb = adv(mb, 22, TB);
      if (vc == m) mc = adv(mc, 23, TC);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load = 1'b0; dvalid = 1'b0; din = 1'b1; key = '0;
    ma = '0; mb = '0; mc = '0; mready = 1'b0;
    #1;
    check(rdy == 1'b0, "R1 ready in reset", 64'(rdy), 64'd0);
    check(ks == 1'b0, "R1 keystream in reset", 64'(ks), 64'd0);
    check(dout == 1'b1, "R1 data passes in reset", 64'(dout), 64'd1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] k;
    logic        ks_before;
    void'($urandom(32'd2024));
    rst_n = 1'b0; load = 1'b0; dvalid = 1'b0; din = 1'b0; key = '0;
    do_reset();

    // R9: valid data before any load is ignored
    for (int i = 0; i < 8; i++) cycle(1'b0, '0, 1'b1, 1'(i), "R9 pre-load");
    check(rdy == 1'b0, "R9 ready still low", 64'(rdy), 64'd0);

    // R2/R3: single one on each top bit identifies the register feeding the output
    cycle(1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R2 load C top");
    cycle(1'b0, '0, 1'b0, 1'b0, "R3 C top");
    check(ks == 1'b1, "R3 C top drives keystream", 64'(ks), 64'd1);
    cycle(1'b1, 64'd1 << 40, 1'b0, 1'b0, "R2 load B top");
    cycle(1'b0, '0, 1'b0, 1'b0, "R3 B top");
    check(ks == 1'b1, "R3 B top drives keystream", 64'(ks), 64'd1);
    cycle(1'b1, 64'd1 << 18, 1'b0, 1'b0, "R2 load A top");
    cycle(1'b0, '0, 1'b0, 1'b0, "R3 A top");
    check(ks == 1'b1, "R3 A top drives keystream", 64'(ks), 64'd1);

    // R5/R6: A votes alone (A[8]=1, B[10]=0, C[10]=0), so A stalls while B and C step
    k = (64'd1 << 8) | (64'd1 << (19 + 20)) | (64'd1 << (41 + 21));
    cycle(1'b1, k, 1'b0, 1'b0, "R5 load lone voter");
    for (int i = 0; i < 30; i++) cycle(1'b0, '0, 1'b1, 1'b0, "R5 R6 lone voter");

    // R7: idle cycles hold the keystream
    ks_before = model_ks();
    for (int i = 0; i < 5; i++) cycle(1'b0, '0, 1'b0, 1'b1, "R7 idle hold");
    check(ks == ks_before, "R7 keystream unchanged", 64'(ks), 64'(ks_before));

    // R8: load collides with valid data; the load wins
    k = {$urandom(), $urandom()};
    cycle(1'b1, k, 1'b1, 1'b1, "R8 load with valid");
    cycle(1'b0, '0, 1'b0, 1'b0, "R8 fresh key shown");

    // R5 R6 R7 R4: random keys, random valid gaps and data
    for (int n = 0; n < 40; n++) begin
      k = {$urandom(), $urandom()};
      cycle(1'b1, k, 1'($urandom_range(0, 1)), 1'b0, "R2 random load");
      for (int i = 0; i < 200; i++)
        cycle(1'b0, '0, ($urandom_range(0, 3) != 0), 1'($urandom()), "R6 random stream");
    end

    // R10: ready stays high, then a reset in mid-stream clears it (R1)
    check(rdy == 1'b1, "R10 ready held", 64'(rdy), 64'd1);
    do_reset();
    cycle(1'b0, '0, 1'b1, 1'b0, "R1 after mid reset");
    check(rdy == 1'b0, "R1 ready cleared", 64'(rdy), 64'd0);
    k = 64'hDEAD_BEEF_0123_4567;
    cycle(1'b1, k, 1'b0, 1'b0, "R2 reload");
    for (int i = 0; i < 50; i++) cycle(1'b0, '0, 1'b1, 1'($urandom()), "R6 after reload");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule